// File: doc/BRIEF.md
# Clock Power-Down Sequencer

This block governs the orderly shutdown and restart of a clock generator that has several single-ended outputs, one group of differential pairs, a crystal oscillator and a frequency synthesizer. It is steered by one active-low control pin. Until that pin is first seen high it is a power-good qualifier. From then on a low level on it is a power-down request. Each request is resynchronized to the sequencer clock and qualified by two consecutive low samples. Every single-ended output is then stopped at its own next falling edge and the differential pairs are forced low. After that the synthesizer enable is dropped, and the oscillator enable one cycle later. On release the pairs are parked high, the oscillator comes back first and the synthesizer after a settling delay. The outputs are ungated only once the synthesizer reports lock.

The controller is a five-state machine. AWAIT_GOOD is the reset state: it waits for power-good and then counts a short start-up window. ACTIVE has the outputs running. DRAIN waits for every output to acknowledge that it has stopped. PARKED is power-down. WAKE restores the enables and waits for lock. The transitions are:
- AWAIT_GOOD to PARKED, on a qualified request inside the window.
- AWAIT_GOOD to WAKE, when the window ends.
- ACTIVE to DRAIN, on a qualified request once every output has acknowledged its start.
- DRAIN to PARKED, when no output acknowledges any longer.
- PARKED to WAKE, on a qualified release after at least one cycle in PARKED.
- WAKE to PARKED, on a qualified request.
- WAKE to ACTIVE, on lock while the synthesizer is enabled.

The analog oscillator, the synthesizer and the pad drivers are outside the block.

Top module: `clkpd_seq`

## Requirements
- R1: After reset, osc_en, pll_en, diff_park_high, lock_timeout and all out_clk are 0 and diff_force_low is 1. While pwr_pin_n has never been sampled high, no enable rises. Once pwr_pin_n is sampled high, power-good stays recorded until reset.
- R2: A low level on pwr_pin_n is a request. It takes effect only when two consecutive seq_clk samples of the synchronized pin are low. A low lasting one seq_clk cycle leaves pll_en at 1, diff_force_low at 0 and the outputs running.
- R3: Every out_clk[i] is src_clk[i] ANDed with an enable that changes only on a falling edge of src_clk[i]. No high pulse is ever shortened or produced outside a full source high phase.
- R4: In power-down, diff_force_low is 1. pll_en falls only after every output has stopped, and osc_en falls at least one seq_clk cycle after pll_en has fallen.
- R5: After a qualified release from PARKED, diff_park_high rises within 8 seq_clk cycles of the pin going high.
- R6: On restart, osc_en rises before pll_en, which follows OSC_SETTLE cycles later. No output runs until pll_locked is 1 with pll_en at 1. All outputs then run within a bounded number of cycles of the release.
- R7: If a qualified request arrives within WIN_CYC cycles after power-good is first seen, the block goes straight to power-down. It never raises osc_en or pll_en and never produces an output pulse.
- R8: lock_timeout rises when pll_locked stays 0 for LOCK_MAX cycles in WAKE. It returns to 0 once the outputs run again.
- R9: A release seen while in DRAIN is ignored. The block still completes the shutdown (pll_en falls) before it restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| seq_clk | input | 1 | Free-running sequencer clock that samples the pin |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_pin_n | input | 1 | Shared pin: power-good first, then active-low power-down request |
| src_clk | input | N_OUT | Single-ended clocks to be gated |
| pll_locked | input | 1 | Synthesizer lock indication |
| out_clk | output | N_OUT | Gated single-ended clocks |
| diff_force_low | output | 1 | Forces the differential pairs low |
| diff_park_high | output | 1 | Drives the stopped differential pairs high during restart |
| osc_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | Synthesizer enable |
| lock_timeout | output | 1 | Lock did not arrive within LOCK_MAX cycles |

## Verification
Embedded properties check on every cycle:
- power-good is never lost once it is recorded;
- a stop follows two low pin samples;
- the synthesizer enable drops only after all stop acknowledgements, and the oscillator enable drops after it;
- on restart the oscillator enable comes before the synthesizer enable;
- the outputs are enabled only after lock;
- DRAIN is held while any output still runs.

The bench scenarios are the only way to show several other properties. These are the absence of runt or truncated pulses across unrelated source clocks, the latency bounds from release to parked-high pairs and to running outputs, the initial power-down within the start-up window, and the lock timeout flag.

// File: rtl/clkpd_pkg.sv
package clkpd_pkg;

    typedef enum logic [2:0] {
        ST_AWAIT_GOOD = 3'd0,
        ST_ACTIVE     = 3'd1,
        ST_DRAIN      = 3'd2,
        ST_PARKED     = 3'd3,
        ST_WAKE       = 3'd4
    } seq_state_e;

endpackage

// File: rtl/clkpd_bit_sync.sv
module clkpd_bit_sync #(
    parameter int   WIDTH   = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                chain[s] <= {WIDTH{RST_VAL}};
            end
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/clkpd_gate_cell.sv
module clkpd_gate_cell #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic gate_req_i,
    output logic clk_o,
    output logic en_o
);

    logic req_s;
    logic en_q;

    // request crosses into the output's own clock domain
    clkpd_bit_sync #(
        .WIDTH   (1),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b0)
    ) u_req_sync (
        .clk   (clk_i),
        .rst_n (rst_n),
        .d     (gate_req_i),
        .q     (req_s)
    );

    // enable moves only while the source is low: no shortened pulse (R3)
    always_ff @(negedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= req_s;
        end
    end

    assign clk_o = clk_i & en_q;
    assign en_o  = en_q;

endmodule

// File: rtl/clkpd_fsm.sv
module clkpd_fsm
    import clkpd_pkg::*;
#(
    parameter int N_OUT      = 3,
    parameter int WIN_CYC    = 8,
    parameter int OSC_SETTLE = 4,
    parameter int LOCK_MAX   = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_s,
    input  logic [N_OUT-1:0] acks_s,
    input  logic             pll_locked,
    output logic             gate_req,
    output logic             osc_en,
    output logic             pll_en,
    output logic             diff_force_low,
    output logic             diff_park_high,
    output logic             lock_timeout
);

    localparam int TMAX_A = (WIN_CYC > OSC_SETTLE) ? WIN_CYC : OSC_SETTLE;
    localparam int TMAX   = (LOCK_MAX > TMAX_A) ? LOCK_MAX : TMAX_A;
    localparam int TW     = $clog2(TMAX + 2);
    localparam logic [TW-1:0] T_SAT    = TW'(TMAX);
    localparam logic [TW-1:0] T_WIN    = TW'(WIN_CYC - 1);
    localparam logic [TW-1:0] T_SETTLE = TW'(OSC_SETTLE);
    localparam logic [TW-1:0] T_LOCK   = TW'(LOCK_MAX - 1);

    seq_state_e    state_q;
    seq_state_e    state_nx;
    logic          pin_d;
    logic          pg_seen_q;
    logic [TW-1:0] tmr_q;
    logic          tmr_clr;
    logic          req_low;
    logic          req_high;
    logic          acks_all;
    logic          acks_none;

    // two consecutive equal samples qualify a level (R2)
    assign req_low   = !pin_s && !pin_d;
    assign req_high  =  pin_s &&  pin_d;
    assign acks_all  = &acks_s;
    assign acks_none = ~|acks_s;
    assign tmr_clr   = (state_nx != state_q) || (!pg_seen_q && pin_s);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_AWAIT_GOOD;
        end else begin
            state_q <= state_nx;
        end
    end

    // pin history, power-good record and dwell timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_d     <= 1'b0;
            pg_seen_q <= 1'b0;
            tmr_q     <= '0;
        end else begin
            pin_d     <= pin_s;
            pg_seen_q <= pg_seen_q | pin_s;
            if (tmr_clr) begin
                tmr_q <= '0;
            end else if (tmr_q != T_SAT) begin
                tmr_q <= tmr_q + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_AWAIT_GOOD: begin
                if (pg_seen_q && req_low) begin
                    state_nx = ST_PARKED;
                end else if (pg_seen_q && tmr_q >= T_WIN) begin
                    state_nx = ST_WAKE;
                end
            end
            ST_ACTIVE: begin
                if (req_low && acks_all) begin
                    state_nx = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (acks_none) begin
                    state_nx = ST_PARKED;
                end
            end
            ST_PARKED: begin
                if (req_high && tmr_q != '0) begin
                    state_nx = ST_WAKE;
                end
            end
            ST_WAKE: begin
                if (req_low) begin
                    state_nx = ST_PARKED;
                end else if (pll_locked && pll_en) begin
                    state_nx = ST_ACTIVE;
                end
            end
            default: state_nx = ST_AWAIT_GOOD;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_req       <= 1'b0;
            osc_en         <= 1'b0;
            pll_en         <= 1'b0;
            diff_force_low <= 1'b1;
            diff_park_high <= 1'b0;
            lock_timeout   <= 1'b0;
        end else begin
            gate_req       <= (state_q == ST_ACTIVE);
            pll_en         <= (state_q == ST_ACTIVE) || (state_q == ST_DRAIN) ||
                              ((state_q == ST_WAKE) && (tmr_q >= T_SETTLE));
            osc_en         <= (state_q == ST_ACTIVE) || (state_q == ST_DRAIN) ||
                              (state_q == ST_WAKE)   || ((state_q == ST_PARKED) && pll_en);
            diff_force_low <= (state_q == ST_AWAIT_GOOD) || (state_q == ST_DRAIN) ||
                              (state_q == ST_PARKED);
            diff_park_high <= (state_q == ST_WAKE);
            if (state_q == ST_ACTIVE) begin
                lock_timeout <= 1'b0;
            end else if ((state_q == ST_WAKE) && !pll_locked && (tmr_q >= T_LOCK)) begin
                lock_timeout <= 1'b1;
            end
        end
    end

    a_r1_good_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_AWAIT_GOOD) |=> (state_q != ST_AWAIT_GOOD));

    a_r2_two_low_samples: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DRAIN) && ($past(state_q) == ST_ACTIVE)) |-> (!$past(pin_s) && !$past(pin_s, 2)));

    a_r4_outputs_before_synth: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_en) |-> (acks_s == '0));

    a_r4_synth_before_osc: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en) |-> (!pll_en && !$past(pll_en)));

    a_r6_osc_before_synth: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_en) |-> (osc_en && $past(osc_en)));

    a_r6_lock_before_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_req) |-> $past(pll_locked && pll_en));

    a_r9_drain_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DRAIN) && (acks_s != '0)) |=> (state_q == ST_DRAIN));

endmodule

// File: rtl/clkpd_seq.sv
module clkpd_seq #(
    parameter int N_OUT      = 3,
    parameter int WIN_CYC    = 8,
    parameter int OSC_SETTLE = 4,
    parameter int LOCK_MAX   = 48
) (
    input  logic             seq_clk,
    input  logic             rst_n,
    input  logic             pwr_pin_n,
    input  logic [N_OUT-1:0] src_clk,
    input  logic             pll_locked,
    output logic [N_OUT-1:0] out_clk,
    output logic             diff_force_low,
    output logic             diff_park_high,
    output logic             osc_en,
    output logic             pll_en,
    output logic             lock_timeout
);

    localparam int SYNC_STAGES = 2;

    logic             pin_s;
    logic             gate_req;
    logic [N_OUT-1:0] en_raw;
    logic [N_OUT-1:0] acks_s;

    clkpd_bit_sync #(
        .WIDTH   (1),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b0)
    ) u_pin_sync (
        .clk   (seq_clk),
        .rst_n (rst_n),
        .d     (pwr_pin_n),
        .q     (pin_s)
    );

    generate
        for (genvar g = 0; g < N_OUT; g++) begin : g_gate
            clkpd_gate_cell #(
                .SYNC_STAGES (SYNC_STAGES)
            ) u_cell (
                .clk_i      (src_clk[g]),
                .rst_n      (rst_n),
                .gate_req_i (gate_req),
                .clk_o      (out_clk[g]),
                .en_o       (en_raw[g])
            );
        end
    endgenerate

    clkpd_bit_sync #(
        .WIDTH   (N_OUT),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b0)
    ) u_ack_sync (
        .clk   (seq_clk),
        .rst_n (rst_n),
        .d     (en_raw),
        .q     (acks_s)
    );

    clkpd_fsm #(
        .N_OUT      (N_OUT),
        .WIN_CYC    (WIN_CYC),
        .OSC_SETTLE (OSC_SETTLE),
        .LOCK_MAX   (LOCK_MAX)
    ) u_fsm (
        .clk            (seq_clk),
        .rst_n          (rst_n),
        .pin_s          (pin_s),
        .acks_s         (acks_s),
        .pll_locked     (pll_locked),
        .gate_req       (gate_req),
        .osc_en         (osc_en),
        .pll_en         (pll_en),
        .diff_force_low (diff_force_low),
        .diff_park_high (diff_park_high),
        .lock_timeout   (lock_timeout)
    );

endmodule

// File: tb/clkpd_seq_tb_top.sv
module clkpd_seq_tb_top;

    localparam int N           = 3;
    localparam int WIN         = 8;
    localparam int SETTLE      = 4;
    localparam int LMAX        = 48;
    localparam int PARK_HI_MAX = 8;
    localparam int TOTAL_MAX   = 80;
    localparam int NVEC        = 4;
    // {low cycles, lock delay, stop expected}
    localparam int VEC [NVEC][3] = '{'{1, 3, 0}, '{2, 3, 1}, '{40, 6, 1}, '{90, 20, 1}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_n = 1'b0;
    logic s0 = 1'b0, s1 = 1'b0, s2 = 1'b0;
    logic pll_locked = 1'b0;
    logic [N-1:0] src;
    logic [N-1:0] out_clk;
    logic diff_force_low, diff_park_high, osc_en, pll_en, lock_timeout;

    int n_chk = 0;
    int n_bad = 0;
    int lock_dly = 3;
    logic lock_block = 1'b0;
    int lock_cnt = 0;
    int osc_rises = 0;
    int pll_rises = 0;
    int pll_falls = 0;
    int osc_order_err = 0;
    int pll_order_err = 0;

    always #5 clk = ~clk;
    always #7 s0 = ~s0;
    always #12 s1 = ~s1;
    always #25 s2 = ~s2;
    assign src = {s2, s1, s0};

    clkpd_seq #(
        .N_OUT (N), .WIN_CYC (WIN), .OSC_SETTLE (SETTLE), .LOCK_MAX (LMAX)
    ) dut_i (
        .seq_clk (clk), .rst_n (rst_n), .pwr_pin_n (pin_n), .src_clk (src),
        .pll_locked (pll_locked), .out_clk (out_clk), .diff_force_low (diff_force_low),
        .diff_park_high (diff_park_high), .osc_en (osc_en), .pll_en (pll_en),
        .lock_timeout (lock_timeout)
    );

    // synthesizer lock model
    always @(posedge clk) begin
        if (!pll_en) begin
            lock_cnt   <= 0;
            pll_locked <= 1'b0;
        end else if (!lock_block) begin
            if (lock_cnt >= lock_dly) pll_locked <= 1'b1;
            else lock_cnt <= lock_cnt + 1;
        end
    end

    always @(posedge osc_en) osc_rises++;
    always @(negedge osc_en) if (pll_en) osc_order_err++;
    always @(posedge pll_en) begin pll_rises++; if (!osc_en) pll_order_err++; end
    always @(negedge pll_en) pll_falls++;

    // per-output pulse monitors (R3, R4, R6)
    for (genvar g = 0; g < N; g++) begin : g_mon
        int rises = 0;
        int runts = 0;
        int order = 0;
        always @(out_clk[g]) begin
            if (out_clk[g] === 1'b1) begin
                rises++;
                if (src[g] !== 1'b1) runts++;
                if (!pll_en || !osc_en || !pll_locked) order++;
            end else if (src[g] === 1'b1) begin
                runts++;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int total_rises();
        return g_mon[0].rises + g_mon[1].rises + g_mon[2].rises;
    endfunction

    task automatic wait_running(output int cyc);
        int b0, b1, b2;
        b0 = g_mon[0].rises; b1 = g_mon[1].rises; b2 = g_mon[2].rises;
        cyc = 0;
        while (!((g_mon[0].rises > b0 + 1) && (g_mon[1].rises > b1 + 1) &&
                 (g_mon[2].rises > b2 + 1)) && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic wait_park_high(output int cyc);
        cyc = 0;
        while (!diff_park_high && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        #1_500_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int cyc;
        int pf;
        int rs;
        repeat (4) @(negedge clk);
        chk("R1 reset osc_en", int'(osc_en), 0);
        chk("R1 reset pll_en", int'(pll_en), 0);
        chk("R1 reset out_clk", int'(out_clk), 0);
        chk("R1 reset diff_force_low", int'(diff_force_low), 1);
        chk("R1 reset diff_park_high", int'(diff_park_high), 0);
        chk("R1 reset lock_timeout", int'(lock_timeout), 0);
        rst_n = 1'b1;

        // pin low before power-good: nothing starts
        repeat (30) @(negedge clk);
        chk("R1 no osc before power-good", osc_rises, 0);
        chk("R1 no pll before power-good", pll_rises, 0);

        // R7: request inside the start-up window
        pin_n = 1'b1;
        repeat (2) @(negedge clk);
        pin_n = 1'b0;
        repeat (40) @(negedge clk);
        chk("R7 osc never enabled", osc_rises, 0);
        chk("R7 pll never enabled", pll_rises, 0);
        chk("R7 no output pulse", total_rises(), 0);
        chk("R7 pairs forced low", int'(diff_force_low), 1);

        // first release: start-up
        pin_n = 1'b1;
        wait_park_high(cyc);
        chk("R5 park high bound at start", int'(cyc <= PARK_HI_MAX), 1);
        wait_running(cyc);
        chk("R6 outputs run after start", int'(cyc < 400), 1);
        chk("R1 power-good kept, pairs released", int'(diff_force_low), 0);

        // vector table
        for (int v = 0; v < NVEC; v++) begin
            lock_dly = VEC[v][1];
            pf = pll_falls;
            @(negedge clk);
            pin_n = 1'b0;
            repeat (VEC[v][0]) @(negedge clk);
            if (VEC[v][0] >= 40) begin
                chk("R4 pairs low in power-down", int'(diff_force_low), 1);
                chk("R4 synth off in power-down", int'(pll_en), 0);
                chk("R4 osc off in power-down", int'(osc_en), 0);
            end
            pin_n = 1'b1;
            if (VEC[v][2] == 0) begin
                rs = total_rises();
                repeat (20) @(negedge clk);
                chk("R2 single low sample ignored, pll stays", pll_falls - pf, 0);
                chk("R2 single low sample, pairs not forced", int'(diff_force_low), 0);
                chk("R2 outputs keep running", int'(total_rises() > rs + 5), 1);
            end else begin
                if (VEC[v][0] >= 40) begin
                    wait_park_high(cyc);
                    chk("R5 park high bound", int'(cyc <= PARK_HI_MAX), 1);
                    wait_running(cyc);
                    chk("R6 release to running bound", int'(cyc + PARK_HI_MAX <= TOTAL_MAX), 1);
                end else begin
                    cyc = 0;
                    while (pll_falls == pf && cyc < 300) begin @(negedge clk); cyc++; end
                    chk("R9 release in drain ignored, shutdown completes", pll_falls - pf, 1);
                    wait_running(cyc);
                    chk("R6 outputs return after drain release", int'(cyc < 400), 1);
                end
                chk("R8 no timeout with timely lock", int'(lock_timeout), 0);
            end
        end

        // R8: lock withheld
        lock_block = 1'b1;
        @(negedge clk);
        pin_n = 1'b0;
        repeat (40) @(negedge clk);
        pin_n = 1'b1;
        repeat (LMAX / 2) @(negedge clk);
        chk("R8 no timeout early", int'(lock_timeout), 0);
        rs = total_rises();
        repeat (LMAX + 20) @(negedge clk);
        chk("R8 timeout raised", int'(lock_timeout), 1);
        chk("R6 outputs held without lock", total_rises() - rs, 0);
        lock_block = 1'b0;
        wait_running(cyc);
        chk("R6 outputs run after late lock", int'(cyc < 400), 1);
        chk("R8 timeout cleared", int'(lock_timeout), 0);

        chk("R3 no runt or truncated pulse", g_mon[0].runts + g_mon[1].runts + g_mon[2].runts, 0);
        chk("R4 outputs silent while synth or lock off", g_mon[0].order + g_mon[1].order + g_mon[2].order, 0);
        chk("R4 osc dropped only after synth", osc_order_err, 0);
        chk("R6 synth enabled only after osc", pll_order_err, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule